// File: doc/BRIEF.md
# Micro-TLB with selective invalidation

A small, fully associative translation cache held in flops. It sits between a fetch or load/store pipeline and the larger main TLB. A lookup carries a virtual page number and an 8-bit address-space identifier. If a valid entry matches both, the physical frame and permission bits come back in the same cycle. If nothing matches, the requester is stalled and a refill request goes to the main TLB. The entry returned is installed into the first free way, or into a round-robin victim when all ways are full.

The main TLB command engine drives three sideband strobes. A flushing write clears every entry. A non-flushing write leaves the contents alone. An explicit invalidate-all also clears every entry, and it does so whatever the main TLB's index register holds at the time. Entries that the main TLB evicts through non-flushing writes therefore stay usable here. The higher associativity of this block hides the low associativity of the main TLB. The default configuration has 8 ways for the data side; set `WAYS` to 4 for the instruction side.

Top module: `utlb_sel`

## Requirements
- R1: With `lk_valid` high and a valid entry whose VPN and ASID both equal the lookup, `lk_hit` is 1 in that same cycle, and `lk_pfn`/`lk_perm` carry that entry's frame and permission bits.
- R2: An entry whose VPN matches but whose ASID differs, or whose ASID matches but whose VPN differs, gives no hit.
- R3: While a lookup misses, `rf_req` is 1 in the same cycle, with `rf_vpn`/`rf_asid` equal to the lookup. The requester holds its lookup stable until the lookup hits.
- R4: A cycle with a missing lookup and `rf_ack` high installs the lookup's VPN/ASID with `rf_pfn`/`rf_perm` at that clock edge, so the next cycle hits.
- R5: An install goes into the lowest-numbered invalid way when one exists.
- R6: With all ways valid, an install replaces the way named by a round-robin pointer. The pointer is 0 after reset, advances by one (wrapping at `WAYS`) on each such replacement, and is not changed by flushes or invalidates.
- R7: `cmd_wr_flush` invalidates every entry at that clock edge.
- R8: `cmd_wr_keep` has no effect on the stored entries.
- R9: `cmd_inval` invalidates every entry at that clock edge, whatever the value of `idx_err`.
- R10: When a flush or invalidate coincides with an install, the clear wins and the new entry is not valid afterwards.
- R11: After reset no entry is valid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Lookup address-space identifier |
| lk_hit | output | 1 | Lookup hit, same cycle |
| lk_pfn | output | PFN_W | Physical frame of the hitting entry |
| lk_perm | output | PERM_W | Permission bits of the hitting entry |
| rf_req | output | 1 | Refill request to the main TLB (requester stalled) |
| rf_vpn | output | VPN_W | VPN being refilled |
| rf_asid | output | ASID_W | ASID being refilled |
| rf_ack | input | 1 | Refill data valid |
| rf_pfn | input | PFN_W | Refill frame |
| rf_perm | input | PERM_W | Refill permission bits |
| cmd_wr_flush | input | 1 | Main TLB write that clears this block |
| cmd_wr_keep | input | 1 | Main TLB write that keeps this block's contents |
| cmd_inval | input | 1 | Explicit invalidate-all |
| idx_err | input | 1 | Main TLB index register holds a lookup error |

## Verification
Hit, frame, permission and refill-request outputs are combinational on the lookup, so they are due in the same cycle as the stimulus. The bench samples them 1 ns after driving inputs on the falling edge. Installs, flushes and invalidates take effect at the next rising edge, so the reference model updates its entry list at that edge and the following cycle's comparison shows the result. Every cycle is compared against a behavioural model. Directed probes check eviction order, the three sideband commands and the clear-versus-install collision.

// File: rtl/utlb_sel.sv
module utlb_sel #(
  parameter int WAYS   = 8,
  parameter int VPN_W  = 20,
  parameter int ASID_W = 8,
  parameter int PFN_W  = 20,
  parameter int PERM_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PERM_W-1:0] lk_perm,
  output logic              rf_req,
  output logic [VPN_W-1:0]  rf_vpn,
  output logic [ASID_W-1:0] rf_asid,
  input  logic              rf_ack,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [PERM_W-1:0] rf_perm,
  input  logic              cmd_wr_flush,
  input  logic              cmd_wr_keep,
  input  logic              cmd_inval,
  input  logic              idx_err
);
  localparam int IDX_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WAYS - 1);

  logic [WAYS-1:0]   valid_q;
  logic [VPN_W-1:0]  vpn_q  [WAYS];
  logic [ASID_W-1:0] asid_q [WAYS];
  logic [PFN_W-1:0]  pfn_q  [WAYS];
  logic [PERM_W-1:0] perm_q [WAYS];
  logic [IDX_W-1:0]  rr_q;

  logic [WAYS-1:0]  match;
  logic             has_free;
  logic [IDX_W-1:0] free_idx, victim;
  logic             clear, install;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn) && (asid_q[g] == lk_asid);
  end

  assign lk_hit  = lk_valid && (|match);
  assign rf_req  = lk_valid && !(|match);
  assign rf_vpn  = lk_vpn;
  assign rf_asid = lk_asid;
  assign clear   = cmd_wr_flush || cmd_inval;
  assign install = rf_req && rf_ack;
  assign victim  = has_free ? free_idx : rr_q;

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (match[i]) begin
        lk_pfn  = lk_pfn | pfn_q[i];
        lk_perm = lk_perm | perm_q[i];
      end
    end
  end

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (!valid_q[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      rr_q    <= '0;
    end else if (clear) begin
      valid_q <= '0;
    end else if (install) begin
      valid_q[victim] <= 1'b1;
      if (!has_free) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (install) begin
      vpn_q[victim]  <= lk_vpn;
      asid_q[victim] <= lk_asid;
      pfn_q[victim]  <= rf_pfn;
      perm_q[victim] <= rf_perm;
    end
  end

  // R1: install only on a miss keeps every tag unique
  a_r1_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R4
  a_r4_install_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (install && !clear) |=> (valid_q != '0));
  // R6
  a_r6_full_stays_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((&valid_q) && !clear) |=> (&valid_q));
  // R7
  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr_flush |=> (valid_q == '0));
  // R8
  a_r8_keep_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_keep && !clear && !install) |=> $stable(valid_q));
  // R9
  a_r9_inval_with_err: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_inval && idx_err) |=> (valid_q == '0));
  // R10
  a_r10_clear_beats_install: assert property (@(posedge clk) disable iff (!rst_n)
    (install && clear) |=> !lk_hit || !$stable(lk_vpn) || !$stable(lk_asid));
endmodule

// File: tb/utlb_sel_tb.sv
module utlb_sel_tb;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic lk_valid = 0, rf_ack = 0, cmd_wr_flush = 0, cmd_wr_keep = 0, cmd_inval = 0, idx_err = 0;
  logic [19:0] lk_vpn = 0, rf_pfn = 0;
  logic [7:0]  lk_asid = 0;
  logic [3:0]  rf_perm = 0;
  logic lk_hit, rf_req;
  logic [19:0] lk_pfn, rf_vpn;
  logic [3:0]  lk_perm;
  logic [7:0]  rf_asid;

  utlb_sel u_dut (.clk, .rst_n, .lk_valid, .lk_vpn, .lk_asid, .lk_hit, .lk_pfn, .lk_perm,
    .rf_req, .rf_vpn, .rf_asid, .rf_ack, .rf_pfn, .rf_perm,
    .cmd_wr_flush, .cmd_wr_keep, .cmd_inval, .idx_err);

  always #10 clk = ~clk;

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit m_v [W];
  logic [19:0] m_vpn [W], m_pfn [W];
  logic [7:0]  m_asid [W];
  logic [3:0]  m_perm [W];
  int m_rr = 0;

  function automatic logic [19:0] mt_pfn(logic [19:0] v, logic [7:0] a);
    return v ^ {a, 12'h5A5};
  endfunction
  function automatic logic [3:0] mt_perm(logic [19:0] v, logic [7:0] a);
    return v[3:0] ^ a[7:4];
  endfunction

  function automatic int m_find();
    for (int i = 0; i < W; i++)
      if (m_v[i] && m_vpn[i] == lk_vpn && m_asid[i] == lk_asid) return i;
    return -1;
  endfunction

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    int f;
    #1;
    f = m_find();
    chk(lk_hit == (lk_valid && f >= 0), "R1/R2 hit", lk_hit, lk_valid && f >= 0);
    if (lk_valid && f >= 0) begin
      chk(lk_pfn == m_pfn[f], "R1 pfn", lk_pfn, m_pfn[f]);
      chk(lk_perm == m_perm[f], "R1 perm", lk_perm, m_perm[f]);
    end
    chk(rf_req == (lk_valid && f < 0), "R3 req", rf_req, lk_valid && f < 0);
    if (rf_req) chk(rf_vpn == lk_vpn && rf_asid == lk_asid, "R3 addr", rf_vpn, lk_vpn);
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < W; i++) m_v[i] = 0;
      m_rr = 0;
    end else if (cmd_wr_flush || cmd_inval) begin
      for (int i = 0; i < W; i++) m_v[i] = 0;
    end else if (lk_valid && f < 0 && rf_ack) begin
      int s = -1;
      for (int i = 0; i < W; i++) if (!m_v[i] && s < 0) s = i;
      if (s < 0) begin s = m_rr; m_rr = (m_rr + 1) % W; end
      m_v[s] = 1; m_vpn[s] = lk_vpn; m_asid[s] = lk_asid;
      m_pfn[s] = rf_pfn; m_perm[s] = rf_perm;
    end
    @(negedge clk);
  endtask

  task automatic access(logic [19:0] v, logic [7:0] a, int lat);
    int n = 0;
    bit fin = 0;
    lk_valid = 1; lk_vpn = v; lk_asid = a;
    while (!fin && n < 40) begin
      bit miss = m_find() < 0;
      rf_ack = miss && n == lat;
      rf_pfn = mt_pfn(v, a); rf_perm = mt_perm(v, a);
      fin = !miss;
      cyc();
      n++;
    end
    lk_valid = 0; rf_ack = 0;
  endtask

  task automatic probe(logic [19:0] v, logic [7:0] a, bit exp, string tag);
    lk_valid = 1; lk_vpn = v; lk_asid = a;
    #1 chk(lk_hit == exp, tag, lk_hit, exp);
    #1 lk_valid = 0;
  endtask

  task automatic pulse(int which, bit err);
    cmd_wr_flush = (which == 0); cmd_wr_keep = (which == 1); cmd_inval = (which == 2); idx_err = err;
    cyc();
    cmd_wr_flush = 0; cmd_wr_keep = 0; cmd_inval = 0; idx_err = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1;
    probe(20'h10, 8'h1, 0, "R11 empty after reset");
    for (int i = 0; i < W; i++) access(20'h100 + 20'(i), 8'h1, i % 3);   // R4 R5
    for (int i = 0; i < W; i++) probe(20'h100 + 20'(i), 8'h1, 1, "R4 refilled hits");
    probe(20'h100, 8'h2, 0, "R2 asid differs");
    probe(20'h1FF, 8'h1, 0, "R2 vpn differs");
    access(20'h200, 8'h1, 1);
    probe(20'h100, 8'h1, 0, "R6 way0 victim");
    probe(20'h101, 8'h1, 1, "R6 way1 kept");
    access(20'h201, 8'h1, 0);
    probe(20'h101, 8'h1, 0, "R6 way1 victim");
    pulse(1, 0);
    probe(20'h102, 8'h1, 1, "R8 keep write leaves entries");
    probe(20'h201, 8'h1, 1, "R8 keep write leaves entries");
    pulse(0, 0);
    probe(20'h102, 8'h1, 0, "R7 flush clears");
    for (int i = 0; i < W; i++) access(20'h300 + 20'(i), 8'h7, 0);
    access(20'h3FF, 8'h7, 0);
    probe(20'h302, 8'h7, 0, "R5/R6 free ways first, pointer kept");
    probe(20'h300, 8'h7, 1, "R5 way0 refilled after flush");
    pulse(2, 1);
    probe(20'h300, 8'h7, 0, "R9 invalidate with index error");
    access(20'h400, 8'h3, 0);
    pulse(2, 0);
    probe(20'h400, 8'h3, 0, "R9 invalidate");
    lk_valid = 1; lk_vpn = 20'h500; lk_asid = 8'h9;
    rf_ack = 1; rf_pfn = mt_pfn(20'h500, 8'h9); rf_perm = 4'h3; cmd_inval = 1;
    cyc();
    rf_ack = 0; cmd_inval = 0;
    #1 chk(!lk_hit, "R10 clear beats install", lk_hit, 0);
    cyc();
    lk_valid = 0;
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom_range(0, 99);
      lk_valid = $urandom_range(0, 3) != 0;
      lk_vpn = 20'($urandom_range(0, 11));
      lk_asid = 8'($urandom_range(1, 2));
      rf_ack = $urandom_range(0, 2) == 0;
      rf_pfn = mt_pfn(lk_vpn, lk_asid); rf_perm = mt_perm(lk_vpn, lk_asid);
      cmd_wr_flush = r < 2; cmd_inval = r >= 2 && r < 4; cmd_wr_keep = r >= 4 && r < 12;
      idx_err = $urandom_range(0, 1) == 1;
      cyc();
    end
    lk_valid = 0; rf_ack = 0; cmd_wr_flush = 0; cmd_inval = 0; cmd_wr_keep = 0;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule